// File: doc/BRIEF.md
# LED Sink Driver Core with Fault-Check Mode

This block is the digital heart of a sixteen-channel constant-current LED sink driver. A host clocks display data in over one serial line. The data passes through a sixteen-stage shift register into a storage latch. An active-low output enable gates the latched word onto sixteen channel on/off controls. The last shift stage is brought out as a serial output, so several cores can be chained.

No extra pins are spent on diagnostics. The latch-enable and output-enable lines double as a key input. When a five-clock pattern appears on them, the core enters a fault-check mode. In that mode, a rising output enable replaces the shift register contents with one health bit per channel. The host then clocks those bits out, channel 15 first.

A second five-clock pattern returns the core to normal mode. The analog side (current sensing and the voltage comparator) is outside this block. Its two per-channel verdicts, low current and high output voltage, arrive as 16-bit vectors.

Top module: `led_sink_core`

## Requirements
- R1: At every rising clock edge that is not a fault capture, the shift register moves one stage toward stage 15 and takes `ser_in` into stage 0. `ser_out` shows stage 15, so a bit reaches `ser_out` 15 clocks after the edge that took it in.
- R2: While `latch_en` is high, the latched word follows the shift register. While it is low, the latched word keeps the value from the last edge at which `latch_en` was high.
- R3: `chan_on[n]` is 1 exactly when latched bit n is 1 and `out_en_n` is 0. All channels are 0 while `out_en_n` is 1.
- R4: In normal mode, the core enters fault-check mode at the fifth of five consecutive rising edges with these samples (oldest first): `out_en_n` = 1,0,1,1,1 and `latch_en` = 0,0,0,1,0. `fault_mode` reads 1 after that edge, and shifting is unaffected.
- R5: In fault-check mode, the core returns to normal mode at the fifth of five consecutive edges with `out_en_n` = 1,0,1,1,1 and `latch_en` = 0,0,0,0,0 (oldest first).
- R6: An entry pattern seen in fault-check mode, or a return pattern seen in normal mode, leaves the mode unchanged.
- R7: The pattern is compared over a sliding five-sample window at every edge. A pattern that starts inside a failed partial match is still recognised.
- R8: In fault-check mode, the core records the fault inputs at every edge that samples `out_en_n` low. At an edge that samples `out_en_n` high right after one that sampled it low, the recorded verdicts are loaded into the shift register instead of shifting. Stage n becomes 1 for a healthy channel and 0 when `fault_open[n]` or `fault_short[n]` was set. `ser_out` then shows channel 15, then 14, and so on, one per clock.
- R9: A synchronous reset with `rst_n` low clears the shift register, the latch and the recorded faults, and selects normal mode. The key history then reads as if `out_en_n` = 1 and `latch_en` = 0 had been sampled four times.
- R10: In normal mode, an `out_en_n` rise does not load fault verdicts: the register keeps shifting display data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_in | input | 1 | Serial data input |
| latch_en | input | 1 | Latch transparency control and key input |
| out_en_n | input | 1 | Active-low output enable and key input |
| fault_open | input | CH | Per-channel low-current (open or ground short) verdict |
| fault_short | input | CH | Per-channel high-voltage (shorted LED) verdict |
| ser_out | output | 1 | Last shift stage |
| chan_on | output | CH | Per-channel sink on/off control |
| fault_mode | output | 1 | High while fault-check mode is active |

## Verification
The bench tests overlapping key patterns. A detector that restarted after a partial match would miss the entry and stay in normal mode. It sends each key pattern in the wrong mode. A detector that simply toggled would flip the mode when it should not. An `out_en_n` pulse in normal mode with every fault line asserted exposes a capture left enabled outside fault-check mode, which would corrupt the serial data. The bench also reads back a mixed fault pattern channel by channel. That catches a reversed bit order, a wrong polarity, and a missing OR of the two fault inputs.

// File: rtl/lsd_pkg.sv
// Shared constants and types for the LED sink driver core.
// Key patterns are written oldest sample in the MSB.
package lsd_pkg;
    localparam int unsigned KEY_LEN = 5;
    localparam logic [KEY_LEN-1:0] KEY_OE_N     = 5'b10111;
    localparam logic [KEY_LEN-1:0] KEY_LE_ENTER = 5'b00010;
    localparam logic [KEY_LEN-1:0] KEY_LE_LEAVE = 5'b00000;

    typedef enum logic {
        MODE_NORMAL = 1'b0,
        MODE_CHECK  = 1'b1
    } core_mode_e;
endpackage

// File: rtl/lsd_key_detect.sv
// Key-sequence detector. Keeps the last KEY_LEN-1 samples of the enable and
// latch lines and compares them, plus the present sample, against the entry
// and leave patterns on every rising edge. Assumes synchronous active-low reset.
module lsd_key_detect
    import lsd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       oe_n,
    input  logic       le,
    output core_mode_e mode_q,
    output logic       oe_n_prev
);
    logic [KEY_LEN-2:0] oe_hist;
    logic [KEY_LEN-2:0] le_hist;
    logic [KEY_LEN-1:0] oe_win;
    logic [KEY_LEN-1:0] le_win;
    logic               enter_hit;
    logic               leave_hit;

    assign oe_win    = {oe_hist, oe_n};
    assign le_win    = {le_hist, le};
    assign oe_n_prev = oe_hist[0];

    // Decide whether the present window completes a valid pattern for the mode.
    always_comb begin
        enter_hit = (mode_q == MODE_NORMAL) && (oe_win == KEY_OE_N) && (le_win == KEY_LE_ENTER);
        leave_hit = (mode_q == MODE_CHECK)  && (oe_win == KEY_OE_N) && (le_win == KEY_LE_LEAVE);
    end

    // Slide the sample history by one position every clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_hist <= '1;
            le_hist <= '0;
        end else begin
            oe_hist <= oe_win[KEY_LEN-2:0];
            le_hist <= le_win[KEY_LEN-2:0];
        end
    end

    // Switch mode on a recognised pattern.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_NORMAL;
        end else if (enter_hit) begin
            mode_q <= MODE_CHECK;
        end else if (leave_hit) begin
            mode_q <= MODE_NORMAL;
        end
    end
endmodule

// File: rtl/lsd_shift_stage.sv
// Serial-in parallel-out shift register with a parallel load override.
// The load wins over shifting. sr_d exposes the value taken at the coming edge.
module lsd_shift_stage #(
    parameter int unsigned CH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ser_in,
    input  logic          load_en,
    input  logic [CH-1:0] load_word,
    output logic [CH-1:0] sr_q,
    output logic [CH-1:0] sr_d
);
    // Select the next register value: parallel load or a one-stage shift.
    always_comb begin
        sr_d = load_en ? load_word : {sr_q[CH-2:0], ser_in};
    end

    // Register the next value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else begin
            sr_q <= sr_d;
        end
    end
endmodule

// File: rtl/lsd_latch_gate.sv
// Storage latch and output gating, one slice per channel.
// While le is high the view follows the shift register directly. The held copy
// is refreshed with the post-edge value, so a fall of le between edges keeps the
// current word. Assumes sr_d is the value sr_q takes at the same edge.
module lsd_latch_gate #(
    parameter int unsigned CH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          le,
    input  logic          oe_n,
    input  logic [CH-1:0] sr_q,
    input  logic [CH-1:0] sr_d,
    output logic [CH-1:0] lat_view,
    output logic [CH-1:0] chan_on
);
    for (genvar c = 0; c < CH; c++) begin : g_ch
        logic held_q;

        // Hold this channel's bit while le is low.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                held_q <= 1'b0;
            end else if (le) begin
                held_q <= sr_d[c];
            end
        end

        assign lat_view[c] = le ? sr_q[c] : held_q;
        assign chan_on[c]  = lat_view[c] & ~oe_n;
    end
endmodule

// File: rtl/led_sink_core.sv
// Top of the LED sink driver digital core. Joins the shift stage, the latch and
// gate slices and the key detector. In fault-check mode it records fault
// verdicts while channels are driven and loads them on the enable rising edge.
// Assumes all inputs are synchronous to clk.
module led_sink_core
    import lsd_pkg::*;
#(
    parameter int unsigned CH = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ser_in,
    input  logic          latch_en,
    input  logic          out_en_n,
    input  logic [CH-1:0] fault_open,
    input  logic [CH-1:0] fault_short,
    output logic          ser_out,
    output logic [CH-1:0] chan_on,
    output logic          fault_mode
);
    core_mode_e    mode_q;
    logic          oe_n_prev;
    logic          load_en;
    logic [CH-1:0] fault_q;
    logic [CH-1:0] sr_q;
    logic [CH-1:0] sr_d;
    logic [CH-1:0] lat_view;

    lsd_key_detect u_key (
        .clk       (clk),
        .rst_n     (rst_n),
        .oe_n      (out_en_n),
        .le        (latch_en),
        .mode_q    (mode_q),
        .oe_n_prev (oe_n_prev)
    );

    // Capture happens on the first edge that sees the enable released in check mode.
    always_comb begin
        load_en = (mode_q == MODE_CHECK) && !oe_n_prev && out_en_n;
    end

    // Record the latest verdicts while the channels are being driven.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault_q <= '0;
        end else if ((mode_q == MODE_CHECK) && !out_en_n) begin
            fault_q <= fault_open | fault_short;
        end
    end

    lsd_shift_stage #(.CH(CH)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_in    (ser_in),
        .load_en   (load_en),
        .load_word (~fault_q),
        .sr_q      (sr_q),
        .sr_d      (sr_d)
    );

    lsd_latch_gate #(.CH(CH)) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .le       (latch_en),
        .oe_n     (out_en_n),
        .sr_q     (sr_q),
        .sr_d     (sr_d),
        .lat_view (lat_view),
        .chan_on  (chan_on)
    );

    assign ser_out    = sr_q[CH-1];
    assign fault_mode = (mode_q == MODE_CHECK);
endmodule

// File: rtl/lsd_checker.sv
// Property checker for led_sink_core, attached with bind below.
module lsd_checker #(
    parameter int unsigned CH = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ser_in,
    input logic          latch_en,
    input logic          out_en_n,
    input logic [CH-1:0] fault_open,
    input logic [CH-1:0] fault_short,
    input logic          ser_out,
    input logic [CH-1:0] chan_on,
    input logic          fault_mode,
    input logic          load_en,
    input logic [CH-1:0] sr_q,
    input logic [CH-1:0] lat_view
);
    a_r1_stage0: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> sr_q[0] == $past(ser_in));

    a_r1_chain: assert property (@(posedge clk) disable iff (!rst_n)
        !load_en |=> sr_q[CH-1:1] == $past(sr_q[CH-2:0]));

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!latch_en && !$past(latch_en)) |-> $stable(lat_view));

    a_r3_blank: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> chan_on == '0);

    a_r3_drive: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en_n |-> chan_on == lat_view);

    a_r4_enter_key: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_mode) |-> ($past(latch_en, 2) && !$past(latch_en) && $past(out_en_n)));

    a_r5_leave_key: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_mode) |-> (!$past(latch_en, 2) && !$past(latch_en) && $past(out_en_n)));

    a_r8_first_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_mode && $rose(out_en_n)) |=>
            ser_out == !($past(fault_open[CH-1], 2) || $past(fault_short[CH-1], 2)));
endmodule

bind led_sink_core lsd_checker #(.CH(CH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ser_in      (ser_in),
    .latch_en    (latch_en),
    .out_en_n    (out_en_n),
    .fault_open  (fault_open),
    .fault_short (fault_short),
    .ser_out     (ser_out),
    .chan_on     (chan_on),
    .fault_mode  (fault_mode),
    .load_en     (load_en),
    .sr_q        (sr_q),
    .lat_view    (lat_view)
);

// File: tb/led_sink_core_tb.sv
module led_sink_core_tb;
    localparam int CH = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ser_in = 1'b0;
    logic          latch_en = 1'b0;
    logic          out_en_n = 1'b1;
    logic [CH-1:0] fault_open = '0;
    logic [CH-1:0] fault_short = '0;
    logic          ser_out;
    logic [CH-1:0] chan_on;
    logic          fault_mode;

    int n_chk = 0;
    int n_fail = 0;
    string phase = "R9";

    // Behavioural reference state
    bit m_sr[$];          // front = stage CH-1
    bit m_lat[CH];
    bit m_flt[CH];
    bit m_mode;
    bit m_prev_oe;
    bit h_oe[$];
    bit h_le[$];

    always #5 clk = ~clk;

    led_sink_core #(.CH(CH)) u_dut (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .latch_en(latch_en),
        .out_en_n(out_en_n), .fault_open(fault_open), .fault_short(fault_short),
        .ser_out(ser_out), .chan_on(chan_on), .fault_mode(fault_mode)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int win_code(bit q[$]);
        int v = 0;
        foreach (q[i]) v = v * 2 + int'(q[i]);
        return v;
    endfunction

    task automatic model_reset();
        m_sr.delete();
        for (int i = 0; i < CH; i++) begin
            m_sr.push_back(1'b0);
            m_lat[i] = 1'b0;
            m_flt[i] = 1'b0;
        end
        m_mode = 1'b0;
        m_prev_oe = 1'b1;
        h_oe.delete();
        h_le.delete();
        for (int i = 0; i < 4; i++) begin
            h_oe.push_back(1'b1);
            h_le.push_back(1'b0);
        end
    endtask

    task automatic model_edge();
        bit next_mode;
        int oc, lc;
        if (!rst_n) begin
            model_reset();
            return;
        end
        h_oe.push_back(out_en_n);
        h_le.push_back(latch_en);
        if (h_oe.size() > 5) begin
            void'(h_oe.pop_front());
            void'(h_le.pop_front());
        end
        oc = win_code(h_oe);
        lc = win_code(h_le);
        next_mode = m_mode;
        if (!m_mode && oc == 23 && lc == 2) next_mode = 1'b1;
        if (m_mode && oc == 23 && lc == 0) next_mode = 1'b0;
        if (m_mode && !m_prev_oe && out_en_n) begin
            m_sr.delete();
            for (int c = CH - 1; c >= 0; c--) m_sr.push_back(!m_flt[c]);
        end else begin
            void'(m_sr.pop_front());
            m_sr.push_back(ser_in);
        end
        if (m_mode && !out_en_n)
            for (int c = 0; c < CH; c++) m_flt[c] = fault_open[c] | fault_short[c];
        if (latch_en)
            for (int c = 0; c < CH; c++) m_lat[c] = m_sr[CH - 1 - c];
        m_prev_oe = out_en_n;
        m_mode = next_mode;
    endtask

    function automatic logic [CH-1:0] model_chan();
        logic [CH-1:0] v;
        for (int c = 0; c < CH; c++)
            v[c] = !out_en_n && (latch_en ? m_sr[CH - 1 - c] : m_lat[c]);
        return v;
    endfunction

    // One clock: drive at the falling edge, model at the rising edge, compare after it.
    task automatic step(input logic oe, input logic le, input logic si);
        @(negedge clk);
        out_en_n = oe;
        latch_en = le;
        ser_in = si;
        @(posedge clk);
        model_edge();
        #1;
        chk({phase, " ser_out"}, 32'(ser_out), 32'(m_sr[0]));
        chk({phase, " chan_on"}, 32'(chan_on), 32'(model_chan()));
        chk({phase, " fault_mode"}, 32'(fault_mode), 32'(m_mode));
    endtask

    task automatic key(input logic [4:0] oe_pat, input logic [4:0] le_pat);
        for (int i = 4; i >= 0; i--) step(oe_pat[i], le_pat[i], 1'b0);
    endtask

    initial begin : watchdog
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [15:0] word;
        model_reset();
        rst_n = 1'b0;
        repeat (3) step(1'b1, 1'b0, 1'b0);
        rst_n = 1'b1;
        // R9: reset state
        chk("R9 ser_out", 32'(ser_out), 0);
        chk("R9 chan_on", 32'(chan_on), 0);
        chk("R9 fault_mode", 32'(fault_mode), 0);

        // R6: leave pattern in normal mode is ignored
        phase = "R6";
        key(5'b10111, 5'b00000);
        chk("R6 leave ignored in normal", 32'(fault_mode), 0);

        // R1/R3: shift a word in with outputs blanked
        phase = "R1";
        for (int i = 15; i >= 0; i--) step(1'b1, 1'b0, 1'(16'hA5C3 >> i));
        chk("R1 msb at ser_out", 32'(ser_out), 1);
        chk("R3 blanked", 32'(chan_on), 0);

        // R10: enable pulse in normal mode with every fault asserted loads nothing
        phase = "R10";
        fault_open = '1;
        fault_short = '1;
        step(1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0);
        chk("R10 no capture in normal", 32'(ser_out), 1);
        fault_open = '0;
        fault_short = '0;

        // R2/R3: latch one word, then hold it while shifting
        phase = "R2";
        step(1'b1, 1'b1, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        chk("R3 drive latched word", 32'(chan_on), 32'h2E18);
        repeat (5) step(1'b0, 1'b0, 1'b1);
        chk("R2 hold while le low", 32'(chan_on), 32'h2E18);
        step(1'b1, 1'b0, 1'b0);
        chk("R3 enable high blanks", 32'(chan_on), 0);

        // R1: lone bit appears 15 clocks after entry
        phase = "R1";
        repeat (16) step(1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b1);
        repeat (14) step(1'b1, 1'b0, 1'b0);
        chk("R1 not yet at 14", 32'(ser_out), 0);
        step(1'b1, 1'b0, 1'b0);
        chk("R1 at 15", 32'(ser_out), 1);

        // R7/R4: entry pattern overlapping a failed partial match
        phase = "R7";
        step(1'b1, 1'b0, 1'b0);
        step(1'b0, 1'b0, 1'b0);
        chk("R4 no early entry", 32'(fault_mode), 0);
        key(5'b10111, 5'b00010);
        chk("R7 overlapped entry", 32'(fault_mode), 1);
        chk("R4 entered check mode", 32'(fault_mode), 1);

        // R6: entry pattern in check mode is ignored
        phase = "R6";
        key(5'b10111, 5'b00010);
        chk("R6 entry ignored in check", 32'(fault_mode), 1);

        // R8: load ones, latch, drive, capture, read back
        phase = "R8";
        repeat (16) step(1'b1, 1'b0, 1'b1);
        step(1'b1, 1'b1, 1'b1);
        fault_open = 16'h0008;
        fault_short = 16'h8100;
        repeat (3) step(1'b0, 1'b0, 1'b1);
        chk("R8 all channels lit", 32'(chan_on), 32'hFFFF);
        step(1'b1, 1'b0, 1'b0);
        word[15] = ser_out;
        for (int c = 14; c >= 0; c--) begin
            step(1'b1, 1'b0, 1'b0);
            word[c] = ser_out;
        end
        chk("R8 verdict word", 32'(word), 32'h7EF7);
        fault_open = '0;
        fault_short = '0;

        // R5: leave pattern returns to normal
        phase = "R5";
        key(5'b10111, 5'b00000);
        chk("R5 back to normal", 32'(fault_mode), 0);
        phase = "R1";
        for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 1'(i % 3 == 0));

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule